// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Doorbell Interrupts

This block is a single-clock memory of 16-bit words with two independent, symmetric ports, called left and right. Each port has an enable, a read/write select, a read-output enable, an address, two byte-lane enables and its own write and read data buses. Both ports can access any location in the same cycle. Writes can touch either byte alone. Read data is registered and appears one clock after the address is sampled. The depth is set by an address-width parameter; 12, 13 and 14 bits give 4K, 8K and 16K words.

The two highest words also act as doorbells between the ports. The top word carries messages from left to right, and the word below it carries messages from right to left. When the sending port writes its doorbell word, the receiving port's active-low interrupt goes low. When the receiving port reads that word, the interrupt is released. Both words still store data like any other location. Software on one side can therefore leave a message word and signal the other side in one write, and the other side acknowledges by reading the message.

Top module: `dpr_mailbox_top`

## Requirements
- R1: While `rst` is high at a clock edge, both read data outputs become zero and both interrupt outputs become high (deasserted).
- R2: A port writes the array only when its `*_en` is high, its `*_rd_wr` is 0 (write) and at least one of its byte enables is high. Any other combination leaves the stored contents unchanged.
- R3: `*_be_hi` gates bits 15:8 and `*_be_lo` gates bits 7:0 of a write, so a write with one byte enable high leaves the other byte of the word as it was.
- R4: A read access (`*_en` high, `*_rd_wr` 1, at least one byte enable high) puts the word on `*_rdata` at the next clock edge. A read of an address written in the same cycle, by either port, returns the contents from before that write.
- R5: `*_rdata` is zero after any cycle that is not a read access with `*_oe` high. In a read, a byte whose enable is low reads as zero.
- R6: If both ports write the same address in the same cycle, the left port's data wins in every byte lane the left port enables. The right port's data is kept only in lanes the left port does not enable.
- R7: A left-port write to address 2^ADDR_W-1 drives `r_irq_n` low after the next clock edge. A right-port write to address 2^ADDR_W-2 drives `l_irq_n` low after the next clock edge.
- R8: A right-port read access of address 2^ADDR_W-1 drives `r_irq_n` high after the next clock edge. A left-port read access of address 2^ADDR_W-2 drives `l_irq_n` high after the next clock edge. In both cases `*_oe` has no effect.
- R9: When the setting write and the releasing read of the same interrupt happen in the same cycle, the interrupt is driven low.
- R10: Only the accesses named in R7 and R8 change an interrupt. Writes by the receiving port, reads by the sending port and accesses to any other address leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable |
| l_rd_wr | input | 1 | Left access type: 1 read, 0 write |
| l_oe | input | 1 | Left read output enable |
| l_be_hi | input | 1 | Left enable for bits 15:8 |
| l_be_lo | input | 1 | Left enable for bits 7:0 |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_rd_wr | input | 1 | Right access type: 1 read, 0 write |
| r_oe | input | 1 | Right read output enable |
| r_be_hi | input | 1 | Right enable for bits 15:8 |
| r_be_lo | input | 1 | Right enable for bits 7:0 |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check the following on every cycle:
- the reset state of the outputs;
- zero read data when the output enable or the access is missing;
- zero in unselected byte lanes;
- the setting, release and hold rules of both interrupts, including set winning over release.

Stored contents can only be seen through later reads. This covers byte-lane merging, ignored writes, the left-wins rule for same-address writes and the old-data result of a read against a same-cycle write. The bench scenarios show these by comparing every read against its behavioural memory model.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int DPR_DATA_W = 16;
  localparam int DPR_LANES  = DPR_DATA_W / 8;
  localparam int DPR_NPORT  = 2;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    logic                 show;
    logic [DPR_LANES-1:0] be;
  } dpr_req_t;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
(
  input  logic     en,
  input  logic     rd_wr,
  input  logic     oe,
  input  logic     be_hi,
  input  logic     be_lo,
  output dpr_req_t req
);
  logic active;

  always_comb begin
    active   = en & (be_hi | be_lo);
    req.be   = {be_hi, be_lo};
    req.wr   = active & ~rd_wr;
    req.rd   = active & rd_wr;
    req.show = active & rd_wr & oe;
  end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  dpr_req_t [DPR_NPORT-1:0]             req,
  input  logic [DPR_NPORT-1:0][ADDR_W-1:0]     addr,
  input  logic [DPR_NPORT-1:0][DPR_DATA_W-1:0] wdata,
  output logic [DPR_NPORT-1:0][DPR_DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DPR_DATA_W-1:0] mem [DEPTH];

  // Highest port index applied first, so port 0 (left) lands last and wins.
  always_ff @(posedge clk) begin
    for (int p = DPR_NPORT - 1; p >= 0; p--) begin
      for (int b = 0; b < DPR_LANES; b++) begin
        if (req[p].wr && req[p].be[b]) begin
          mem[addr[p]][b*8 +: 8] <= wdata[p][b*8 +: 8];
        end
      end
    end
  end

  for (genvar p = 0; p < DPR_NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[p] <= '0;
      end else if (req[p].show) begin
        for (int b = 0; b < DPR_LANES; b++) begin
          rdata[p][b*8 +: 8] <= req[p].be[b] ? mem[addr[p]][b*8 +: 8] : 8'h00;
        end
      end else begin
        rdata[p] <= '0;
      end
    end
  end
endmodule

// File: rtl/dpr_doorbell.sv
module dpr_doorbell
  import dpr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MB_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  dpr_req_t          snd_req,
  input  logic [ADDR_W-1:0] snd_addr,
  input  dpr_req_t          rcv_req,
  input  logic [ADDR_W-1:0] rcv_addr,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] MB = ADDR_W'(MB_ADDR);

  logic ring, ack;

  always_comb begin
    ring = snd_req.wr && (snd_addr == MB);
    ack  = rcv_req.rd && (rcv_addr == MB);
  end

  always_ff @(posedge clk) begin
    if (rst)       irq_n <= 1'b1;
    else if (ring) irq_n <= 1'b0;
    else if (ack)  irq_n <= 1'b1;
  end
endmodule

// File: rtl/dpr_mailbox_top.sv
module dpr_mailbox_top
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_rd_wr,
  input  logic              l_oe,
  input  logic              l_be_hi,
  input  logic              l_be_lo,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [15:0]       l_wdata,
  output logic [15:0]       l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_rd_wr,
  input  logic              r_oe,
  input  logic              r_be_hi,
  input  logic              r_be_lo,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [15:0]       r_wdata,
  output logic [15:0]       r_rdata,
  output logic              r_irq_n
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DPR_NPORT-1:0]                 en_v, rw_v, oe_v, hi_v, lo_v;
  logic [DPR_NPORT-1:0][ADDR_W-1:0]     addr_v;
  logic [DPR_NPORT-1:0][DPR_DATA_W-1:0] wdata_v, rdata_v;
  logic [DPR_NPORT-1:0]                 irq_v;
  dpr_req_t [DPR_NPORT-1:0]             req_v;

  assign en_v    = {r_en, l_en};
  assign rw_v    = {r_rd_wr, l_rd_wr};
  assign oe_v    = {r_oe, l_oe};
  assign hi_v    = {r_be_hi, l_be_hi};
  assign lo_v    = {r_be_lo, l_be_lo};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  for (genvar p = 0; p < DPR_NPORT; p++) begin : g_port
    dpr_port_decode u_dec (
      .en    (en_v[p]),
      .rd_wr (rw_v[p]),
      .oe    (oe_v[p]),
      .be_hi (hi_v[p]),
      .be_lo (lo_v[p]),
      .req   (req_v[p])
    );
  end

  dpr_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .req   (req_v),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (rdata_v)
  );

  // Direction d: sender d, receiver 1-d; doorbell word at DEPTH-1-d.
  for (genvar d = 0; d < DPR_NPORT; d++) begin : g_bell
    dpr_doorbell #(.ADDR_W(ADDR_W), .MB_ADDR(DEPTH - 1 - d)) u_bell (
      .clk      (clk),
      .rst      (rst),
      .snd_req  (req_v[d]),
      .snd_addr (addr_v[d]),
      .rcv_req  (req_v[1-d]),
      .rcv_addr (addr_v[1-d]),
      .irq_n    (irq_v[1-d])
    );
  end

  assign l_rdata = rdata_v[0];
  assign r_rdata = rdata_v[1];
  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];
endmodule

// File: rtl/dpr_mailbox_chk.sv
module dpr_mailbox_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              l_en,
  input logic              l_rd_wr,
  input logic              l_oe,
  input logic              l_be_hi,
  input logic              l_be_lo,
  input logic [ADDR_W-1:0] l_addr,
  input logic [15:0]       l_rdata,
  input logic              l_irq_n,
  input logic              r_en,
  input logic              r_rd_wr,
  input logic              r_oe,
  input logic              r_be_hi,
  input logic              r_be_lo,
  input logic [ADDR_W-1:0] r_addr,
  input logic [15:0]       r_rdata,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

  logic l_rd, l_wr, r_rd, r_wr;
  logic r_set, r_clr, l_set, l_clr;
  assign l_rd  = l_en && (l_be_hi || l_be_lo) && l_rd_wr;
  assign l_wr  = l_en && (l_be_hi || l_be_lo) && !l_rd_wr;
  assign r_rd  = r_en && (r_be_hi || r_be_lo) && r_rd_wr;
  assign r_wr  = r_en && (r_be_hi || r_be_lo) && !r_rd_wr;
  assign r_set = l_wr && l_addr == TOP;
  assign r_clr = r_rd && r_addr == TOP;
  assign l_set = r_wr && r_addr == NXT;
  assign l_clr = l_rd && l_addr == NXT;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (l_rdata == '0 && r_rdata == '0 && l_irq_n && r_irq_n)); // R1
  AST_L_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(l_rd && l_oe) |=> l_rdata == '0); // R5
  AST_R_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(r_rd && r_oe) |=> r_rdata == '0); // R5
  AST_L_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    (!l_be_hi |=> l_rdata[15:8] == 8'h00) and (!l_be_lo |=> l_rdata[7:0] == 8'h00)); // R5
  AST_R_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    (!r_be_hi |=> r_rdata[15:8] == 8'h00) and (!r_be_lo |=> r_rdata[7:0] == 8'h00)); // R5
  AST_R_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    r_set |=> !r_irq_n); // R7 R9
  AST_L_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    l_set |=> !l_irq_n); // R7 R9
  AST_R_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (r_clr && !r_set) |=> r_irq_n); // R8
  AST_L_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (l_clr && !l_set) |=> l_irq_n); // R8
  AST_R_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!r_set && !r_clr) |=> $stable(r_irq_n)); // R10
  AST_L_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!l_set && !l_clr) |=> $stable(l_irq_n)); // R10
endmodule

bind dpr_mailbox_top dpr_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dpr_mailbox_top.sv
`timescale 1ns/1ps
module sim_dpr_mailbox_top;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int TOP   = DEPTH - 1;
  localparam int NXT   = DEPTH - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en = 0, l_rd_wr = 1, l_oe = 0, l_be_hi = 0, l_be_lo = 0;
  logic r_en = 0, r_rd_wr = 1, r_oe = 0, r_be_hi = 0, r_be_lo = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_wdata = '0, r_wdata = '0;
  logic [15:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  dpr_mailbox_top #(.ADDR_W(AW)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mm [DEPTH];
  logic [15:0] e_lr, e_rr;
  logic        e_li, e_ri;

  task automatic setp(input bit right, input bit en, input bit rw, input bit oe,
                      input bit hi, input bit lo, input int a, input logic [15:0] d);
    if (right) begin
      r_en = en; r_rd_wr = rw; r_oe = oe; r_be_hi = hi; r_be_lo = lo;
      r_addr = AW'(a); r_wdata = d;
    end else begin
      l_en = en; l_rd_wr = rw; l_oe = oe; l_be_hi = hi; l_be_lo = lo;
      l_addr = AW'(a); l_wdata = d;
    end
  endtask

  task automatic idle();
    setp(0, 0, 1, 0, 0, 0, 0, 16'h0);
    setp(1, 0, 1, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: model the coming rising edge, then compare.
  task automatic cyc(input string tag);
    bit lw, lr, rw_, rr;
    logic [15:0] ol, orr;
    lw  = l_en && (l_be_hi || l_be_lo) && !l_rd_wr;
    lr  = l_en && (l_be_hi || l_be_lo) && l_rd_wr;
    rw_ = r_en && (r_be_hi || r_be_lo) && !r_rd_wr;
    rr  = r_en && (r_be_hi || r_be_lo) && r_rd_wr;
    if (rst) begin
      e_lr = 0; e_rr = 0; e_li = 1; e_ri = 1;
    end else begin
      ol  = mm[int'(l_addr)];
      orr = mm[int'(r_addr)];
      e_lr = (lr && l_oe) ? {l_be_hi ? ol[15:8] : 8'h00, l_be_lo ? ol[7:0] : 8'h00} : 16'h0;
      e_rr = (rr && r_oe) ? {r_be_hi ? orr[15:8] : 8'h00, r_be_lo ? orr[7:0] : 8'h00} : 16'h0;
      if (lw && int'(l_addr) == TOP) e_ri = 0;
      else if (rr && int'(r_addr) == TOP) e_ri = 1;
      if (rw_ && int'(r_addr) == NXT) e_li = 0;
      else if (lr && int'(l_addr) == NXT) e_li = 1;
      if (rw_) begin
        if (r_be_hi) mm[int'(r_addr)][15:8] = r_wdata[15:8];
        if (r_be_lo) mm[int'(r_addr)][7:0]  = r_wdata[7:0];
      end
      if (lw) begin
        if (l_be_hi) mm[int'(l_addr)][15:8] = l_wdata[15:8];
        if (l_be_lo) mm[int'(l_addr)][7:0]  = l_wdata[7:0];
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "l_rdata", l_rdata, e_lr);
    chk(tag, "r_rdata", r_rdata, e_rr);
    chk(tag, "l_irq_n", {15'h0, l_irq_n}, {15'h0, e_li});
    chk(tag, "r_irq_n", {15'h0, r_irq_n}, {15'h0, e_ri});
  endtask

  task automatic rd(input bit right, input int a, input string tag);
    idle(); setp(right, 1, 1, 1, 1, 1, a, 16'h0); cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle();
    // R1: reset state
    cyc("R1"); cyc("R1");
    rst = 0;
    // Fill memory through the left port (sets r_irq_n at TOP)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); setp(0, 1, 0, 0, 1, 1, a, 16'(a * 16'h9E37 + 16'h1234)); cyc("R2");
    end
    rd(1, TOP, "R8");  // releases r_irq_n
    rd(0, 5, "R4");

    // R3: single-lane writes
    idle(); setp(0, 1, 0, 0, 1, 0, 10, 16'hAB00); cyc("R3");
    rd(0, 10, "R3");
    idle(); setp(1, 1, 0, 0, 0, 1, 10, 16'h00CD); cyc("R3");
    rd(1, 10, "R3");

    // R2: writes lacking enable or byte enables, and reads, change nothing
    idle(); setp(0, 0, 0, 0, 1, 1, 11, 16'hDEAD); cyc("R2");
    idle(); setp(1, 1, 0, 0, 0, 0, 11, 16'hBEEF); cyc("R2");
    idle(); setp(0, 1, 1, 0, 1, 1, 11, 16'h5555); cyc("R2");
    rd(0, 11, "R2");

    // R4: read-first against same-cycle write from the other port
    idle(); setp(0, 1, 0, 0, 1, 1, 20, 16'h7777); setp(1, 1, 1, 1, 1, 1, 20, 0); cyc("R4");
    rd(1, 20, "R4");

    // R5: output enable low, partial lane read
    idle(); setp(0, 1, 1, 0, 1, 1, 20, 0); cyc("R5");
    idle(); setp(1, 1, 1, 1, 0, 1, 20, 0); cyc("R5");
    idle(); setp(0, 0, 1, 1, 1, 1, 20, 0); cyc("R5");

    // R6: both write same address
    idle(); setp(0, 1, 0, 0, 1, 1, 30, 16'h1111); setp(1, 1, 0, 0, 1, 1, 30, 16'h2222); cyc("R6");
    rd(0, 30, "R6");
    idle(); setp(0, 1, 0, 0, 1, 0, 30, 16'h3300); setp(1, 1, 0, 0, 1, 1, 30, 16'h4444); cyc("R6");
    rd(1, 30, "R6");

    // R7/R8: doorbells both directions
    idle(); setp(0, 1, 0, 0, 0, 1, TOP, 16'h00A5); cyc("R7");
    idle(); setp(1, 1, 0, 0, 1, 1, NXT, 16'h5A5A); cyc("R7");
    // R10: wrong-side accesses leave interrupts alone
    idle(); setp(0, 1, 1, 1, 1, 1, TOP, 0); setp(1, 1, 1, 1, 1, 1, NXT, 0); cyc("R10");
    idle(); setp(1, 1, 0, 0, 1, 1, TOP, 16'h0F0F); setp(0, 1, 0, 0, 1, 1, NXT, 16'hF0F0); cyc("R10");
    idle(); setp(1, 1, 1, 1, 1, 1, 7, 0); cyc("R10");
    // R8: release with oe low
    idle(); setp(1, 1, 1, 0, 1, 1, TOP, 0); setp(0, 1, 1, 0, 0, 1, NXT, 0); cyc("R8");
    cyc("R8");
    // R9: set and release in one cycle, both directions
    idle(); setp(0, 1, 0, 0, 1, 1, TOP, 16'hC0DE); setp(1, 1, 1, 1, 1, 1, TOP, 0); cyc("R9");
    idle(); setp(1, 1, 0, 0, 1, 1, NXT, 16'hFACE); setp(0, 1, 1, 1, 1, 1, NXT, 0); cyc("R9");
    rd(1, TOP, "R8"); rd(0, NXT, "R8");

    // Mixed random traffic around the doorbells, checked against the model
    for (int i = 0; i < 3000; i++) begin
      int sel;
      for (int p = 0; p < 2; p++) begin
        sel = $urandom_range(0, 9);
        setp(p[0], $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 1),
             sel == 0 ? TOP : sel == 1 ? NXT : sel, 16'($urandom()));
      end
      cyc("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule